// File: doc/BRIEF.md
# Staggered-Window Lookup-Table Input Selector

This block feeds the four address inputs of a 4-input lookup table from a pool of 15 source lines. Each table input has a private multiplexer. That multiplexer covers only a sliding window of twelve consecutive sources, offset by the input's own position, so 48 crosspoints replace the 60 of a full crossbar. Each input still decodes its own 4-bit select field without looking at the other fields. The inputs of a lookup table are interchangeable, so any four distinct sources can still reach the table when they are assigned in ascending order.

A configuration encoder sits in front of the select registers. It takes four distinct source indices, presented in any slot order. It ranks them and writes, for the input of each rank, the offset of that source inside the input's window. A requested set with a repeated index or an out-of-range index is refused and leaves the routing unchanged. The select fields can also be written directly. A direct write can hold an out-of-window code, which disables that input and raises a sticky flag. The 16-bit truth table is held in its own register. The multiplexers and the table read are combinational. Source count and table width are parameters: with 19 sources the same 16 select bits give 16-wide windows and 64 crosspoints.

Top module: `lut_window_selector`

## Requirements
- R1: After reset, all select fields are 0, the truth table is 0, `lut_out` is 0, and both `req_err` and `sel_err` are 0.
- R2: Table input i, given a select code c with 0 <= c <= N-K, carries source `src[i+c]`. Select field i sits at bits [4i+3:4i] of `sel_q` and `sel_wdata`.
- R3: `lut_out` equals truth-table bit `tt_q[a]`, where address bit i of a is table input i (input 0 is the least significant bit). A `tt_load` replaces the table at the next clock edge.
- R4: A `req_valid` cycle with four distinct indices below N, in any slot order (slot j at bits [4j+3:4j] of `req_idx`), writes select codes for the ascending indices s0<s1<s2<s3. Field i gets s_i - i at the next edge and `req_err` goes to 0.
- R5: For every 4-of-15 source set, after encoding, `lut_out` equals the truth-table bit addressed by the requested source values taken in ascending index order, with the lowest index as address bit 0.
- R6: A request containing a repeated index sets `req_err` at the next edge and leaves every select field unchanged.
- R7: A request containing an index of N or more sets `req_err` at the next edge and leaves every select field unchanged.
- R8: A select code above N-K forces that table input to 0. It sets `sel_err`, which then stays 1 until reset, even after legal codes are loaded.
- R9: `req_err` holds its value until the next request, and an accepted request clears it.
- R10: When `sel_load` and `req_valid` are both asserted in one cycle, `sel_wdata` is the value written to the select fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 15 | Source lines; bit n is source n |
| req_valid | input | 1 | Encode the requested index set this cycle |
| req_idx | input | 16 | Four 4-bit requested source indices, any order |
| sel_load | input | 1 | Write select fields directly |
| sel_wdata | input | 16 | Direct select field value |
| tt_load | input | 1 | Write the truth table |
| tt_wdata | input | 16 | Truth table value |
| sel_q | output | 16 | Current select fields |
| req_err | output | 1 | Last request was refused |
| sel_err | output | 1 | Sticky out-of-window code flag |
| lut_out | output | 1 | Lookup-table result |

## Verification
The routing path is exercised with all 1365 four-source sets. Each set is requested in a rotated or swapped slot order, so the encoder's ranking is checked apart from the order in which indices arrive. Each set is paired with a random truth table and two random source words, which separates a wrong window offset from a wrong address bit position. Directed patterns load a single live source at the far end of a window and one-hot or single-column truth tables, which isolates one input at a time. Requests with repeated or too-large indices, mixed with accepted ones, distinguish a refused update from a held error flag. A direct load of an out-of-window code shows that the input is forced low and that the error flag stays set.

// File: rtl/lws_pkg.sv
package lws_pkg;

   // width of one select field for a window of n-k+1 sources
   function automatic int field_width(input int n, input int k);
      int span;
      span = n - k + 1;
      return (span < 2) ? 1 : $clog2(span);
   endfunction

   // width of a source index
   function automatic int index_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lws_encoder.sv
module lws_encoder
   import lws_pkg::*;
#(
   parameter int N    = 15,
   parameter int K    = 4,
   parameter int IDXW = index_width(N),
   parameter int SELW = field_width(N, K)
) (
   input  logic [K*IDXW-1:0] req_idx,
   output logic [K*SELW-1:0] enc_sel,
   output logic              enc_bad
);

   logic [IDXW-1:0] idx  [K];
   int              rank [K];
   logic            dup_hit;
   logic            range_hit;

   for (genvar j = 0; j < K; j++) begin : g_unpack
      assign idx[j] = req_idx[j*IDXW +: IDXW];
   end

   // rank of each request = number of smaller requests
   always_comb begin
      for (int j = 0; j < K; j++) begin
         rank[j] = 0;
         for (int m = 0; m < K; m++) begin
            if (idx[m] < idx[j]) rank[j] = rank[j] + 1;
         end
      end
   end

   always_comb begin
      dup_hit   = 1'b0;
      range_hit = 1'b0;
      for (int j = 0; j < K; j++) begin
         if (int'(idx[j]) >= N) range_hit = 1'b1;
         for (int m = j + 1; m < K; m++) begin
            if (idx[m] == idx[j]) dup_hit = 1'b1;
         end
      end
   end

   assign enc_bad = dup_hit | range_hit;

   // input r takes the request of rank r, offset into its window
   always_comb begin
      enc_sel = '0;
      for (int r = 0; r < K; r++) begin
         for (int j = 0; j < K; j++) begin
            if (rank[j] == r) begin
               enc_sel[r*SELW +: SELW] = enc_sel[r*SELW +: SELW]
                                       | SELW'(int'(idx[j]) - r);
            end
         end
      end
   end

endmodule

// File: rtl/lws_window_mux.sv
module lws_window_mux
   import lws_pkg::*;
#(
   parameter int N    = 15,
   parameter int K    = 4,
   parameter int POS  = 0,
   parameter int SELW = field_width(N, K)
) (
   input  logic [N-1:0]    src,
   input  logic [SELW-1:0] code,
   output logic            pin,
   output logic            code_bad
);

   localparam int SPAN = N - K + 1;

   logic [SPAN-1:0] win;
   assign win = src[POS +: SPAN];

   if (SPAN == (1 << SELW)) begin : g_full
      // every code lands inside the window
      assign code_bad = 1'b0;
      assign pin      = win[code];
   end else begin : g_guard
      always_comb begin
         code_bad = (int'(code) >= SPAN);
         pin      = 1'b0;
         for (int c = 0; c < SPAN; c++) begin
            if (int'(code) == c) pin = win[c];
         end
      end
   end

endmodule

// File: rtl/lws_lut.sv
module lws_lut #(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] table_bits,
   input  logic [K-1:0]      addr,
   output logic              dout
);

   assign dout = table_bits[addr];

endmodule

// File: rtl/lut_window_selector.sv
module lut_window_selector
   import lws_pkg::*;
#(
   parameter int N = 15,
   parameter int K = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [N-1:0]                    src,
   input  logic                            req_valid,
   input  logic [K*index_width(N)-1:0]     req_idx,
   input  logic                            sel_load,
   input  logic [K*field_width(N,K)-1:0]   sel_wdata,
   input  logic                            tt_load,
   input  logic [(1<<K)-1:0]               tt_wdata,
   output logic [K*field_width(N,K)-1:0]   sel_q,
   output logic                            req_err,
   output logic                            sel_err,
   output logic                            lut_out
);

   localparam int IDXW = index_width(N);
   localparam int SELW = field_width(N, K);
   localparam int SPAN = N - K + 1;
   localparam int TTW  = 1 << K;

   if (K < 1)         begin : g_chk_k  $error("K must be at least 1");        end
   if (N < K)         begin : g_chk_n  $error("N must not be below K");       end
   if (N > (1<<IDXW)) begin : g_chk_iw $error("index width too narrow");      end

   logic [K*SELW-1:0] enc_sel;
   logic              enc_bad;
   logic [K*SELW-1:0] sel_nxt;
   logic              nxt_bad;
   logic [TTW-1:0]    tt_q;
   logic [K-1:0]      pins;
   logic [K-1:0]      pin_bad;

   lws_encoder #(.N(N), .K(K), .IDXW(IDXW), .SELW(SELW)) u_enc (
      .req_idx (req_idx),
      .enc_sel (enc_sel),
      .enc_bad (enc_bad)
   );

   always_comb begin
      if (sel_load)                    sel_nxt = sel_wdata;
      else if (req_valid && !enc_bad)  sel_nxt = enc_sel;
      else                             sel_nxt = sel_q;
   end

   always_comb begin
      nxt_bad = 1'b0;
      for (int i = 0; i < K; i++) begin
         if (int'(sel_nxt[i*SELW +: SELW]) >= SPAN) nxt_bad = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         tt_q    <= '0;
         req_err <= 1'b0;
         sel_err <= 1'b0;
      end else begin
         sel_q   <= sel_nxt;
         sel_err <= sel_err | nxt_bad;
         if (tt_load)   tt_q    <= tt_wdata;
         if (req_valid) req_err <= enc_bad;
      end
   end

   for (genvar i = 0; i < K; i++) begin : g_in
      lws_window_mux #(.N(N), .K(K), .POS(i), .SELW(SELW)) u_mux (
         .src      (src),
         .code     (sel_q[i*SELW +: SELW]),
         .pin      (pins[i]),
         .code_bad (pin_bad[i])
      );
   end

   lws_lut #(.K(K)) u_lut (
      .table_bits (tt_q),
      .addr       (pins & ~pin_bad),
      .dout       (lut_out)
   );

endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
   parameter int N    = 15,
   parameter int K    = 4,
   parameter int SELW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              sel_load,
   input logic              enc_bad,
   input logic [K*SELW-1:0] sel_q,
   input logic              req_err,
   input logic              sel_err
);

   localparam int SPAN = N - K + 1;

   logic any_illegal;
   logic ascending;

   always_comb begin
      any_illegal = 1'b0;
      ascending   = 1'b1;
      for (int i = 0; i < K; i++) begin
         if (int'(sel_q[i*SELW +: SELW]) >= SPAN) any_illegal = 1'b1;
         if (i > 0) begin
            if (int'(sel_q[i*SELW +: SELW]) + i <= int'(sel_q[(i-1)*SELW +: SELW]) + i - 1)
               ascending = 1'b0;
         end
      end
   end

   assert_sticky_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |=> sel_err);

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_err) |-> any_illegal);

   assert_refused_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && enc_bad && !sel_load) |=> $stable(sel_q) && req_err);

   assert_accept_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !enc_bad) |=> !req_err);

   assert_accept_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !enc_bad && !sel_load) |=> (ascending && !any_illegal));

endmodule

bind lut_window_selector lws_checker #(.N(N), .K(K), .SELW(SELW)) u_lws_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .sel_load  (sel_load),
   .enc_bad   (enc_bad),
   .sel_q     (sel_q),
   .req_err   (req_err),
   .sel_err   (sel_err)
);

// File: tb/tb_lut_window_selector.sv
module tb_lut_window_selector;

   localparam int CLK_PERIOD = 10;
   localparam int N = 15;
   localparam int K = 4;

   typedef struct {
      bit          c_lut;
      bit          e_lut;
      bit          c_sel;
      logic [15:0] e_sel;
      bit          c_re;
      bit          e_re;
      bit          c_se;
      bit          e_se;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] src = '0;
   logic        req_valid = 1'b0;
   logic [15:0] req_idx = '0;
   logic        sel_load = 1'b0;
   logic [15:0] sel_wdata = '0;
   logic        tt_load = 1'b0;
   logic [15:0] tt_wdata = '0;
   logic [15:0] sel_q;
   logic        req_err, sel_err, lut_out;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;
   exp_t expq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lut_window_selector #(.N(N), .K(K)) dut (
      .clk(clk), .rst_n(rst_n), .src(src),
      .req_valid(req_valid), .req_idx(req_idx),
      .sel_load(sel_load), .sel_wdata(sel_wdata),
      .tt_load(tt_load), .tt_wdata(tt_wdata),
      .sel_q(sel_q), .req_err(req_err), .sel_err(sel_err), .lut_out(lut_out)
   );

   // monitor: one scoreboard item per cycle, compared at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (expq.size() > 0) begin
            exp_t it;
            it = expq.pop_front();
            if (it.c_lut) begin
               nvec++;
               if (lut_out !== it.e_lut) begin
                  nbad++;
                  $display("FAIL %s lut_out act=%b exp=%b", it.tag, lut_out, it.e_lut);
               end
            end
            if (it.c_sel) begin
               nvec++;
               if (sel_q !== it.e_sel) begin
                  nbad++;
                  $display("FAIL %s sel_q act=%h exp=%h", it.tag, sel_q, it.e_sel);
               end
            end
            if (it.c_re) begin
               nvec++;
               if (req_err !== it.e_re) begin
                  nbad++;
                  $display("FAIL %s req_err act=%b exp=%b", it.tag, req_err, it.e_re);
               end
            end
            if (it.c_se) begin
               nvec++;
               if (sel_err !== it.e_se) begin
                  nbad++;
                  $display("FAIL %s sel_err act=%b exp=%b", it.tag, sel_err, it.e_se);
               end
            end
         end
      end
   end

   function automatic exp_t none();
      exp_t e;
      e.c_lut = 0; e.e_lut = 0; e.c_sel = 0; e.e_sel = '0;
      e.c_re = 0; e.e_re = 0; e.c_se = 0; e.e_se = 0; e.tag = "";
      return e;
   endfunction

   // push expectation for this cycle, then advance one clock
   task automatic step(input exp_t e);
      expq.push_back(e);
      @(posedge clk);
      #1;
   endtask

   task automatic idle_inputs();
      req_valid = 1'b0; sel_load = 1'b0; tt_load = 1'b0;
   endtask

   // reference: sorted indices, lowest is address bit 0
   function automatic bit ref_lut(input logic [15:0] tt, input logic [14:0] s,
                                  input int a, input int b, input int c, input int d);
      logic [3:0] adr;
      adr = {s[d], s[c], s[b], s[a]};
      return tt[adr];
   endfunction

   task automatic check_lut(input bit v, input string tag);
      exp_t e;
      e = none(); e.c_lut = 1; e.e_lut = v; e.tag = tag;
      step(e);
   endtask

   initial begin
      exp_t e;
      int cnt;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1: reset state
      src = 15'h7FFF;
      e = none(); e.tag = "R1";
      e.c_lut = 1; e.e_lut = 0; e.c_sel = 1; e.e_sel = 16'h0000;
      e.c_re = 1; e.e_re = 0; e.c_se = 1; e.e_se = 0;
      step(e);

      // R2: input 2 at far window end (code 11 -> src[13]); table = address bit 2
      sel_load = 1; sel_wdata = 16'h0B00; tt_load = 1; tt_wdata = 16'hF0F0;
      step(none());
      idle_inputs();
      src = 15'h2000;
      e = none(); e.tag = "R2"; e.c_lut = 1; e.e_lut = 1; e.c_sel = 1; e.e_sel = 16'h0B00;
      step(e);
      src = 15'h5FFF;
      check_lut(0, "R2");
      // R2: input 0 code 11 -> src[11]; table = address bit 0
      sel_load = 1; sel_wdata = 16'h000B; tt_load = 1; tt_wdata = 16'hAAAA;
      step(none());
      idle_inputs();
      src = 15'h0800;
      check_lut(1, "R2");
      src = 15'h77FF;
      check_lut(0, "R2");

      // R3: table only at address 15, codes all 0 -> AND of src[3:0]
      sel_load = 1; sel_wdata = 16'h0000; tt_load = 1; tt_wdata = 16'h8000;
      step(none());
      idle_inputs();
      src = 15'h000F;
      check_lut(1, "R3");
      src = 15'h0007;
      check_lut(0, "R3");

      // R10: direct write wins over a simultaneous request
      sel_load = 1; sel_wdata = 16'h1234; req_valid = 1; req_idx = 16'h3210;
      step(none());
      idle_inputs();
      e = none(); e.tag = "R10"; e.c_sel = 1; e.e_sel = 16'h1234;
      step(e);

      // R4: request {9,1,7,4} -> fields 1,3,5,6
      req_valid = 1; req_idx = 16'h4719;
      step(none());
      idle_inputs();
      e = none(); e.tag = "R4"; e.c_sel = 1; e.e_sel = 16'h6531; e.c_re = 1; e.e_re = 0;
      step(e);

      // R6: repeated index refused
      req_valid = 1; req_idx = 16'h9744;
      step(none());
      idle_inputs();
      e = none(); e.tag = "R6"; e.c_sel = 1; e.e_sel = 16'h6531; e.c_re = 1; e.e_re = 1;
      step(e);
      e = none(); e.tag = "R9"; e.c_re = 1; e.e_re = 1;
      step(e);

      // R9: accepted request clears error; {0,2,5,14} -> 0,1,3,11
      req_valid = 1; req_idx = 16'h52E0;
      step(none());
      idle_inputs();
      e = none(); e.tag = "R9"; e.c_sel = 1; e.e_sel = 16'hB310; e.c_re = 1; e.e_re = 0;
      step(e);

      // R7: index 15 refused
      req_valid = 1; req_idx = 16'h43F2;
      step(none());
      idle_inputs();
      src = 15'h4025;
      e = none(); e.tag = "R7"; e.c_sel = 1; e.e_sel = 16'hB310; e.c_re = 1; e.e_re = 1;
      e.c_lut = 1; e.e_lut = 1;
      step(e);

      // R5: every 4-of-15 set, varied slot order, random table and sources
      cnt = 0;
      for (int a = 0; a < N; a++)
         for (int b = a + 1; b < N; b++)
            for (int c = b + 1; c < N; c++)
               for (int d = c + 1; d < N; d++) begin
                  int s[4];
                  int p[4];
                  logic [15:0] tt;
                  s[0] = a; s[1] = b; s[2] = c; s[3] = d;
                  for (int j = 0; j < 4; j++) p[j] = s[(j + cnt) % 4];
                  if (((cnt / 4) % 2) == 1) begin
                     int t;
                     t = p[0]; p[0] = p[2]; p[2] = t;
                  end
                  tt = 16'($urandom);
                  req_valid = 1;
                  req_idx = {4'(p[3]), 4'(p[2]), 4'(p[1]), 4'(p[0])};
                  tt_load = 1; tt_wdata = tt;
                  step(none());
                  idle_inputs();
                  src = 15'($urandom);
                  e = none(); e.tag = "R5";
                  e.c_sel = 1; e.e_sel = {4'(d - 3), 4'(c - 2), 4'(b - 1), 4'(a)};
                  e.c_re = 1; e.e_re = 0;
                  e.c_lut = 1; e.e_lut = ref_lut(tt, src, a, b, c, d);
                  step(e);
                  src = 15'($urandom);
                  check_lut(ref_lut(tt, src, a, b, c, d), "R5");
                  cnt++;
               end

      // R8: out-of-window code on input 1 forces it low and sets sticky flag
      sel_load = 1; sel_wdata = 16'h00D0; tt_load = 1; tt_wdata = 16'hCCCC;
      step(none());
      idle_inputs();
      src = 15'h7FFF;
      e = none(); e.tag = "R8"; e.c_lut = 1; e.e_lut = 0; e.c_se = 1; e.e_se = 1;
      step(e);
      sel_load = 1; sel_wdata = 16'h0010;
      step(none());
      idle_inputs();
      e = none(); e.tag = "R8"; e.c_lut = 1; e.e_lut = 1; e.c_se = 1; e.e_se = 1;
      step(e);

      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         nbad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule